// File: doc/BRIEF.md
# 256-bit Vector Permute Unit

This unit performs data movement on 256-bit vectors split into two 128-bit lanes. A single opcode selects one of eight operations: three scalar broadcasts (32, 64 and 128 bits), insertion of a 128-bit operand into one half of a vector, extraction of one half, an element shuffle that stays inside each lane for 32-bit or 64-bit elements, and a selection of 128-bit blocks from two sources driven by an immediate byte.

One operation is accepted on every cycle that `in_valid` is high. Its result appears in an output register one clock later, with `out_valid` marking it. When no operation is issued, the result register keeps its last value. The unit performs no memory access and raises no exceptions.

Top module: `vperm_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `result` are cleared to zero.
- R2: An operation issued with `in_valid` high appears on `result` with `out_valid` high after exactly one rising edge. A cycle without `in_valid` gives `out_valid` low at the next edge, and `result` keeps its previous value.
- R3: Opcode 0 (32-bit broadcast) writes `opnd[31:0]` into all eight 32-bit elements of the result.
- R4: Opcode 1 (64-bit broadcast) writes `opnd[63:0]` into all four 64-bit elements. Opcode 2 (128-bit broadcast) writes `opnd` into both halves.
- R5: Opcode 3 (insert) returns `src_a` with one half replaced by `opnd`. `imm[0]=0` replaces bits 127:0 and `imm[0]=1` replaces bits 255:128. The other half keeps the value from `src_a`.
- R6: Opcode 4 (extract) puts `src_a[127:0]` (when `imm[0]=0`) or `src_a[255:128]` (when `imm[0]=1`) into result bits 127:0, and sets bits 255:128 to zero.
- R7: Opcode 5 (32-bit in-lane shuffle) sets destination element i (0..7) to `src_a` element 4*(i/4) + `ctrl[32*i+1:32*i]`.
- R8: Opcode 6 (64-bit in-lane shuffle) sets destination element j (0..3) to `src_a` element 2*(j/2) + `ctrl[64*j]`.
- R9: Opcode 7 (block select) fills result bits 127:0 from the block chosen by `imm[1:0]` and bits 255:128 from the block chosen by `imm[5:4]`. Block 0 is `src_a[127:0]`, block 1 is `src_a[255:128]`, block 2 is `src_b[127:0]` and block 3 is `src_b[255:128]`.
- R10: For opcode 7, `imm[3]=1` forces result bits 127:0 to zero and `imm[7]=1` forces bits 255:128 to zero, whatever the selectors say.
- R11: Inputs not named for an opcode have no effect on its result. This covers `imm[7:1]` for insert and extract, `imm[2]` and `imm[6]` for block select, and the `ctrl` bits above each element's selector for the shuffles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Opcode (0..7 as in the requirements) |
| src_a | input | 256 | First vector source |
| src_b | input | 256 | Second vector source (block select only) |
| opnd | input | 128 | Scalar or 128-bit operand for broadcast and insert |
| imm | input | 8 | Immediate control byte |
| ctrl | input | 256 | Per-element shuffle selectors |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 256 | Registered result |

## Verification
Two events can fall in the same cycle. The first is one result leaving the output register while the next operation, with a different opcode, is being captured. The second, inside a block select, is a zero override on a half whose selector also points at a live block. The bench issues long runs of back-to-back operations with random opcodes and operands, with no idle cycle between them, so every output edge also loads a new result. A scoreboard compares each result in order against an independent model. Block selects sweep all selector and zero-bit combinations. Idle cycles placed after a burst confirm that the last result holds.

// File: rtl/vperm_pkg.sv
// Package: shared opcode encoding for the vector permute unit.
// Assumes a 3-bit opcode field driven by the issuing logic.
package vperm_pkg;
    typedef enum logic [2:0] {
        OP_BC32 = 3'd0,
        OP_BC64 = 3'd1,
        OP_BC128 = 3'd2,
        OP_INS  = 3'd3,
        OP_EXT  = 3'd4,
        OP_SH32 = 3'd5,
        OP_SH64 = 3'd6,
        OP_BSEL = 3'd7
    } vp_op_e;
endpackage

// File: rtl/vperm_bcast.sv
// Module: replicates one scalar across a whole vector.
// Assumes VEC_W is an integer multiple of SCALAR_W. Purely combinational.
module vperm_bcast #(
    parameter int VEC_W    = 256,
    parameter int SCALAR_W = 32
) (
    input  logic [SCALAR_W-1:0] scalar,
    output logic [VEC_W-1:0]    vec
);
    localparam int COPIES = VEC_W / SCALAR_W;

    // one copy of the scalar per element slot
    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        assign vec[k*SCALAR_W +: SCALAR_W] = scalar;
    end
endmodule

// File: rtl/vperm_lane_shuf.sv
// Module: in-lane element shuffle. Each destination element picks a source
// element from its own lane, using the low bits of the matching control element.
// Assumes LANE_W divides VEC_W and ELEM_W divides LANE_W. Combinational.
module vperm_lane_shuf #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int ELEM_W = 32
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] ctrl,
    output logic [VEC_W-1:0] dst
);
    localparam int NUM_LANES = VEC_W / LANE_W;
    localparam int EPL       = LANE_W / ELEM_W;
    localparam int SEL_W     = (EPL > 1) ? $clog2(EPL) : 1;

    // only the low selector bits of each control element are consumed
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [ELEM_W-1:0] elems [EPL];
        // split this lane into its elements
        for (genvar e = 0; e < EPL; e++) begin : g_split
            assign elems[e] = src[l*LANE_W + e*ELEM_W +: ELEM_W];
        end
        // pick each destination element from the same lane
        for (genvar d = 0; d < EPL; d++) begin : g_pick
            logic [SEL_W-1:0] sel;
            assign sel = ctrl[(l*EPL + d)*ELEM_W +: SEL_W];
            assign dst[(l*EPL + d)*ELEM_W +: ELEM_W] = elems[sel];
        end
    end
endmodule

// File: rtl/vperm_blk_sel.sv
// Module: two-source 128-bit block select. Each result half takes one of four
// blocks through a 2-bit field of the immediate, or zero when its kill bit is set.
// Assumes a vector of exactly two lanes. Combinational.
module vperm_blk_sel #(
    parameter int LANE_W = 128
) (
    input  logic [2*LANE_W-1:0] src_a,
    input  logic [2*LANE_W-1:0] src_b,
    input  logic [7:0]          imm,
    output logic [2*LANE_W-1:0] dst
);
    localparam int NUM_BLK = 4;

    logic [LANE_W-1:0] blk [NUM_BLK];
    // imm[2] and imm[6] are reserved
    logic unused_imm;
    assign unused_imm = ^imm;

    // block numbering: a.lo, a.hi, b.lo, b.hi
    assign blk[0] = src_a[LANE_W-1:0];
    assign blk[1] = src_a[2*LANE_W-1:LANE_W];
    assign blk[2] = src_b[LANE_W-1:0];
    assign blk[3] = src_b[2*LANE_W-1:LANE_W];

    // each half: a selector in imm[4h+1:4h], a kill bit in imm[4h+3]
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [1:0] sel;
        logic       kill;
        assign sel  = imm[4*h +: 2];
        assign kill = imm[4*h + 3];
        assign dst[h*LANE_W +: LANE_W] = kill ? '0 : blk[sel];
    end
endmodule

// File: rtl/vperm_unit.sv
// Module: 256-bit vector permute unit, top level. Decodes the opcode, chooses
// among the broadcast, insert/extract, in-lane shuffle and block select
// datapaths, and registers the result with a one-cycle latency.
// Assumes synchronous active-low reset and one operation per cycle at most.
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [2*LANE_W-1:0] src_a,
    input  logic [2*LANE_W-1:0] src_b,
    input  logic [LANE_W-1:0]   opnd,
    input  logic [7:0]          imm,
    input  logic [2*LANE_W-1:0] ctrl,
    output logic                out_valid,
    output logic [2*LANE_W-1:0] result
);
    localparam int VEC_W = 2 * LANE_W;

    vp_op_e           op_e;
    logic [VEC_W-1:0] bc32_v, bc64_v, bc128_v, sh32_v, sh64_v, bsel_v, nxt;

    assign op_e = vp_op_e'(op);

    vperm_bcast #(.VEC_W(VEC_W), .SCALAR_W(32)) u_bc32 (
        .scalar(opnd[31:0]), .vec(bc32_v));
    vperm_bcast #(.VEC_W(VEC_W), .SCALAR_W(64)) u_bc64 (
        .scalar(opnd[63:0]), .vec(bc64_v));
    vperm_bcast #(.VEC_W(VEC_W), .SCALAR_W(LANE_W)) u_bc128 (
        .scalar(opnd), .vec(bc128_v));

    vperm_lane_shuf #(.VEC_W(VEC_W), .LANE_W(LANE_W), .ELEM_W(32)) u_sh32 (
        .src(src_a), .ctrl(ctrl), .dst(sh32_v));
    vperm_lane_shuf #(.VEC_W(VEC_W), .LANE_W(LANE_W), .ELEM_W(64)) u_sh64 (
        .src(src_a), .ctrl(ctrl), .dst(sh64_v));

    vperm_blk_sel #(.LANE_W(LANE_W)) u_bsel (
        .src_a(src_a), .src_b(src_b), .imm(imm), .dst(bsel_v));

    // opcode-driven choice of the next result
    always_comb begin
        unique case (op_e)
            OP_BC32:  nxt = bc32_v;
            OP_BC64:  nxt = bc64_v;
            OP_BC128: nxt = bc128_v;
            OP_INS:   nxt = imm[0] ? {opnd, src_a[LANE_W-1:0]}
                                   : {src_a[VEC_W-1:LANE_W], opnd};
            OP_EXT:   nxt = {{LANE_W{1'b0}},
                             (imm[0] ? src_a[VEC_W-1:LANE_W] : src_a[LANE_W-1:0])};
            OP_SH32:  nxt = sh32_v;
            OP_SH64:  nxt = sh64_v;
            OP_BSEL:  nxt = bsel_v;
            default:  nxt = '0;
        endcase
    end

    // result register: loads on issue, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R4
    bc128_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_BC128) |=> result[VEC_W-1:LANE_W] == result[LANE_W-1:0]);
    // R5
    ins_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_INS && !imm[0])
        |=> result[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W]));
    // R6
    ext_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_EXT) |=> result[VEC_W-1:LANE_W] == '0);
    // R10
    bsel_kill_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_BSEL && imm[3]) |=> result[LANE_W-1:0] == '0);
    // R10
    bsel_kill_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_BSEL && imm[7]) |=> result[VEC_W-1:LANE_W] == '0);
endmodule

// File: tb/vperm_unit_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard-based check of vperm_unit. A driver task issues operations
// and queues the model result; a monitor pops and compares on each out_valid.
module vperm_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [2:0]   op;
    logic [255:0] src_a, src_b, ctrl;
    logic [127:0] opnd;
    logic [7:0]   imm;
    logic         out_valid;
    logic [255:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    logic [255:0] exp_q [$];
    string        tag_q [$];
    logic [255:0] last_exp = '0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    vperm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .opnd(opnd), .imm(imm), .ctrl(ctrl),
        .out_valid(out_valid), .result(result));

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    // independent reference model
    function automatic logic [255:0] model(input logic [2:0] o, input logic [255:0] a,
        input logic [255:0] b, input logic [127:0] s, input logic [7:0] im,
        input logic [255:0] c);
        logic [255:0] r;
        logic [127:0] blk;
        int sidx;
        r = '0;
        case (o)
            3'd0: for (int i = 0; i < 8; i++) r[32*i +: 32] = s[31:0];
            3'd1: for (int i = 0; i < 4; i++) r[64*i +: 64] = s[63:0];
            3'd2: r = {s, s};
            3'd3: begin r = a; if (im[0]) r[255:128] = s; else r[127:0] = s; end
            3'd4: r[127:0] = im[0] ? a[255:128] : a[127:0];
            3'd5: for (int i = 0; i < 8; i++) begin
                      sidx = (i / 4) * 4 + int'(c[32*i +: 2]);
                      r[32*i +: 32] = a[32*sidx +: 32];
                  end
            3'd6: for (int j = 0; j < 4; j++) begin
                      sidx = (j / 2) * 2 + int'(c[64*j]);
                      r[64*j +: 64] = a[64*sidx +: 64];
                  end
            default: for (int h = 0; h < 2; h++) begin
                      case (im[4*h +: 2])
                          2'd0: blk = a[127:0];
                          2'd1: blk = a[255:128];
                          2'd2: blk = b[127:0];
                          default: blk = b[255:128];
                      endcase
                      r[128*h +: 128] = im[4*h + 3] ? 128'd0 : blk;
                  end
        endcase
        return r;
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // driver: issue one operation and queue its expected result
    task automatic issue(input logic [2:0] o, input logic [255:0] a, input logic [255:0] b,
                         input logic [127:0] s, input logic [7:0] im,
                         input logic [255:0] c, input string tag);
        @(negedge clk);
        op = o; src_a = a; src_b = b; opnd = s; imm = im; ctrl = c;
        in_valid = 1'b1;
        exp_q.push_back(model(o, a, b, s, im, c));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = rnd256(); src_b = rnd256(); imm = 8'($urandom);
    endtask

    // monitor: compare each produced result in order
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", result, '0);
            end else begin
                logic [255:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(result === e, t, result, e);
                last_exp = e;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [255:0] a, b, c;
        logic [127:0] s;
        rst_n = 1'b0; in_valid = 1'b1; op = 3'd2;
        src_a = '1; src_b = '1; opnd = '1; imm = '1; ctrl = '1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid === 1'b0, "R1 out_valid", {255'd0, out_valid}, '0);
        chk(result === '0, "R1 result", result, '0);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b1;

        a = rnd256(); b = rnd256(); s = {$urandom, $urandom, $urandom, $urandom};
        issue(3'd0, a, b, s, 8'h00, '0, "R3 bc32");
        issue(3'd1, a, b, s, 8'h00, '0, "R4 bc64");
        issue(3'd2, a, b, s, 8'h00, '0, "R4 bc128");
        issue(3'd3, a, b, s, 8'h00, '0, "R5 insert low");
        issue(3'd3, a, b, s, 8'h01, '0, "R5 insert high");
        issue(3'd4, a, b, s, 8'h00, '0, "R6 extract low");
        issue(3'd4, a, b, s, 8'h01, '0, "R6 extract high");
        // R7 reversal within each lane
        c = '0;
        for (int i = 0; i < 8; i++) c[32*i +: 2] = 2'(3 - (i % 4));
        issue(3'd5, a, b, s, 8'h00, c, "R7 reverse");
        issue(3'd6, a, b, s, 8'h00, {64'd0, 64'd1, 64'd0, 64'd1}, "R8 swap");
        // R11 junk imm and upper ctrl bits
        issue(3'd3, a, b, s, 8'hFE, '0, "R11 insert junk imm");
        issue(3'd4, a, b, s, 8'hF1, '0, "R11 extract junk imm");
        issue(3'd5, a, b, s, 8'h5A, c | {8{32'hFFFF_FFFC}}, "R11 shuf32 junk ctrl");
        issue(3'd6, a, b, s, 8'h00, {4{64'hFFFF_FFFF_FFFF_FFFE}}, "R11 shuf64 junk ctrl");
        issue(3'd7, a, b, s, 8'h44 | 8'h21, '0, "R11 bsel reserved bits");
        // R9 and R10: every selector pair with every kill pair
        for (int k = 0; k < 256; k++) begin
            logic [7:0] im;
            im = 8'(k);
            issue(3'd7, a, b, s, im & 8'hBB,
                  '0, (im[3] || im[7]) ? "R10 bsel kill" : "R9 bsel");
        end
        // back-to-back random stream
        for (int n = 0; n < 400; n++) begin
            logic [2:0] o;
            o = 3'($urandom);
            issue(o, rnd256(), rnd256(), {$urandom, $urandom, $urandom, $urandom},
                  8'($urandom), rnd256(), op_tag(o));
            if (n % 50 == 49) begin
                idle();
                @(negedge clk); #1;
                chk(out_valid === 1'b0, "R2 idle valid", {255'd0, out_valid}, '0);
                chk(result === last_exp, "R2 hold", result, last_exp);
            end
        end
        idle();
        repeat (2) begin
            @(negedge clk); #1;
            chk(out_valid === 1'b0, "R2 idle valid", {255'd0, out_valid}, '0);
            chk(result === last_exp, "R2 hold", result, last_exp);
        end
        chk(exp_q.size() == 0, "R2 all results seen", 256'(exp_q.size()), '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule